// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives up to 24 LEDs through a chain of external serial-in, parallel-out shift registers, using three pins: serial data, shift clock and store strobe. A CPU writes a 24-bit output image and a small set of control fields over a simple word-addressed register bus. The bus has a write strobe and a combinational read port.

Each refresh takes a snapshot of the image and shifts out only the 8-bit groups that are enabled, one bit per shift-clock period. It then raises the store strobe so that the external registers present the new pattern. A refresh is started in one of two ways. In periodic mode a prescaler starts one at one of four slow rates. In software mode a CPU request starts exactly one. The shift edge can be chosen to suit the external registers. Outputs 0 and 1 can each be taken from a two-bit hardware input instead of the image.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset every register reads 0, the store strobe and serial data are low, and the shift clock rests at its idle level, which is low while the edge select is 0.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (configuration) and 0x08 (image); every other offset reads 0.
  - Control: bit 31 is the software request, bit 30 is busy (read only), bit 26 is the edge select, and bits 25:24 are the override enables for outputs 1:0.
  - Configuration: bits 31:30 are the update source, bits 26:23 are the rate code, and bits 2:0 enable groups 2..0.
  - Image: bits 23:0; the upper image bits read back as 0.
- R3: A refresh shifts only the enabled groups. Groups go out from the highest enabled one downwards, and within a group from bit 7 to bit 0. The first bit sent ends up furthest down the external chain.
- R4: With edge select 0 the shift clock idles low, and each bit is valid across a rising edge. With edge select 1 it idles high, and each bit is valid across a falling edge. Serial data changes only while the clock is at its idle level.
- R5: After the last bit the store strobe is high for exactly one shift-clock period (2·SHIFT_HALF system clocks), with the shift clock idle.
- R6: When override enable bit 24 (or bit 25) is set, output 0 (or 1) is taken from hw_src[0] (or hw_src[1]) at snapshot time.
- R7: In software mode (update source not 2'b10), writing 1 to control bit 31 starts one refresh. Bit 31 then reads 1 until that refresh ends and 0 afterwards, and bit 30 reads 1 while the refresh is under way.
- R8: With update source 2'b10, a refresh starts every CLK_HZ/(f·SIM_DIV) system clocks. Rate codes 0, 1 and 2 give f = 2, 4 and 8 Hz; code 3 and every code above it give 10 Hz.
- R9: In periodic mode a write of 1 to control bit 31 is ignored, and the bit reads 0.
- R10: Writes to the image during a refresh do not change the bits being shifted.
- R11: With no group enabled, a refresh produces a store pulse and no shift-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_src | input | 2 | Hardware values for outputs 1:0 |
| led_sdata | output | 1 | Serial data to the shift-register chain |
| led_sclk | output | 1 | Shift clock |
| led_store | output | 1 | Store (latch) strobe |

## Verification
The hardest situation to reach from the ports is a refresh interval measured with no transient in it. A change of rate code or source mode leaves the prescaler partway through a period, so the first interval after the change is not meaningful. The bench therefore counts store-strobe rising edges and times only the gap between the second and third edges after each configuration change. It repeats this for the slowest code, the fastest code and an out-of-range code. Snapshot isolation is reached the same way: a software refresh is started, and a few dozen cycles into the shift the image is overwritten.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_STORE = 2'd2
   } eng_state_t;

   // update source code that selects periodic refresh
   localparam logic [1:0] UPD_PERIODIC = 2'b10;

   // number of rate codes that carry a distinct frequency
   localparam int unsigned NUM_RATES = 4;

   // refresh frequency in Hz for a rate code; codes past the table use the fastest
   function automatic int unsigned rate_hz(input int unsigned code);
      case (code)
         0:       rate_hz = 2;
         1:       rate_hz = 4;
         2:       rate_hz = 8;
         default: rate_hz = 10;
      endcase
   endfunction

endpackage

// File: rtl/led_shift_regs.sv
module led_shift_regs
   import led_shift_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned NGRP   = 3,
   parameter int unsigned GRP_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wen,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic                   busy,
   input  logic                   done,
   output logic                   req_pend,
   output logic                   edge_fall,
   output logic [1:0]             ovr,
   output logic                   periodic,
   output logic [3:0]             rate,
   output logic [NGRP-1:0]        grp_en,
   output logic [NGRP*GRP_W-1:0]  image
);

   localparam int unsigned IMG_W  = NGRP * GRP_W;
   localparam int unsigned WIDX_W = ADDR_W - 2;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("led_shift_regs: ADDR_W must be at least 4");
   end
   if (IMG_W > 32 || NGRP > 23) begin : g_bad_img
      $error("led_shift_regs: image must fit below the configuration fields");
   end

   logic [WIDX_W-1:0] widx;
   logic              wr_ctl, wr_cfg, wr_img;
   logic [1:0]        upd;
   logic              unused_bits;

   assign widx   = bus_addr[ADDR_W-1:2];
   assign wr_ctl = bus_wen && (widx == WIDX_W'(0));
   assign wr_cfg = bus_wen && (widx == WIDX_W'(1));
   assign wr_img = bus_wen && (widx == WIDX_W'(2));
   assign periodic = (upd == UPD_PERIODIC);
   assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_fall <= 1'b0;
         ovr       <= '0;
         upd       <= '0;
         rate      <= '0;
         grp_en    <= '0;
         image     <= '0;
         req_pend  <= 1'b0;
      end else begin
         if (wr_ctl) begin
            edge_fall <= bus_wdata[26];
            ovr       <= bus_wdata[25:24];
         end
         if (wr_cfg) begin
            upd    <= bus_wdata[31:30];
            rate   <= bus_wdata[26:23];
            grp_en <= bus_wdata[NGRP-1:0];
         end
         if (wr_img) begin
            image <= bus_wdata[IMG_W-1:0];
         end
         if (wr_ctl && bus_wdata[31] && !periodic) begin
            req_pend <= 1'b1;
         end else if (done) begin
            req_pend <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (widx)
         WIDX_W'(0): begin
            bus_rdata[31]    = req_pend;
            bus_rdata[30]    = busy;
            bus_rdata[26]    = edge_fall;
            bus_rdata[25:24] = ovr;
         end
         WIDX_W'(1): begin
            bus_rdata[31:30]    = upd;
            bus_rdata[26:23]    = rate;
            bus_rdata[NGRP-1:0] = grp_en;
         end
         WIDX_W'(2): bus_rdata[IMG_W-1:0] = image;
         default: ;
      endcase
   end

endmodule

// File: rtl/led_shift_rate.sv
module led_shift_rate
   import led_shift_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned SIM_DIV = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] code,
   output logic       tick
);

   localparam int unsigned P_SLOW = CLK_HZ / (rate_hz(0) * SIM_DIV);
   localparam int unsigned P_FAST = CLK_HZ / (rate_hz(NUM_RATES - 1) * SIM_DIV);
   localparam int unsigned CNT_W  = $clog2(P_SLOW + 1);

   if (SIM_DIV < 1) begin : g_bad_div
      $error("led_shift_rate: SIM_DIV must be at least 1");
   end
   if (P_FAST < 2) begin : g_bad_clk
      $error("led_shift_rate: CLK_HZ too low for the fastest rate");
   end

   logic [CNT_W-1:0] lim [NUM_RATES];
   logic [CNT_W-1:0] cnt;
   logic [1:0]       sel;
   logic             wrap;

   for (genvar k = 0; k < NUM_RATES; k++) begin : g_lim
      assign lim[k] = CNT_W'(CLK_HZ / (rate_hz(k) * SIM_DIV) - 1);
   end

   assign sel  = (code > 4'd3) ? 2'd3 : code[1:0];
   assign wrap = (cnt >= lim[sel]);
   assign tick = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || wrap) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/led_shift_engine.sv
module led_shift_engine
   import led_shift_pkg::*;
#(
   parameter int unsigned NGRP  = 3,
   parameter int unsigned GRP_W = 8,
   parameter int unsigned HALF  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [NGRP*GRP_W-1:0]  image,
   input  logic [NGRP-1:0]        grp_en,
   input  logic [1:0]             ovr,
   input  logic [1:0]             hw_src,
   input  logic                   edge_fall,
   output logic                   sclk,
   output logic                   sdata,
   output logic                   store,
   output logic                   busy,
   output logic                   done
);

   localparam int unsigned IMG_W = NGRP * GRP_W;
   localparam int unsigned BIT_W = $clog2(IMG_W + 1);

   if (HALF < 1) begin : g_bad_half
      $error("led_shift_engine: HALF must be at least 1");
   end
   if (IMG_W < 2 || GRP_W < 1) begin : g_bad_img
      $error("led_shift_engine: image must hold the two override bits");
   end

   eng_state_t       state;
   logic             phase;
   logic             half_end;
   logic [IMG_W-1:0] shreg, snap, compact;
   logic [BIT_W-1:0] left, nbits;
   int               fill;

   // half shift-clock period timer; a plain strobe when one cycle per half
   if (HALF == 1) begin : g_nodiv
      assign half_end = 1'b1;
   end else begin : g_div
      localparam int unsigned DIV_W = $clog2(HALF);
      logic [DIV_W-1:0] div;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div <= '0;
         end else if (state == ST_IDLE || half_end) begin
            div <= '0;
         end else begin
            div <= div + 1'b1;
         end
      end
      assign half_end = (div == DIV_W'(HALF - 1));
   end

   // override substitution on the snapshot
   always_comb begin
      snap = image;
      if (ovr[0]) snap[0] = hw_src[0];
      if (ovr[1]) snap[1] = hw_src[1];
   end

   // pack enabled groups at the top, highest group first
   always_comb begin
      compact = '0;
      fill    = 0;
      for (int g = NGRP - 1; g >= 0; g--) begin
         if (grp_en[g]) begin
            compact[IMG_W - 1 - fill * GRP_W -: GRP_W] = snap[g * GRP_W +: GRP_W];
            fill = fill + 1;
         end
      end
      nbits = BIT_W'(fill * GRP_W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         phase <= 1'b0;
         shreg <= '0;
         left  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  shreg <= compact;
                  left  <= nbits;
                  phase <= 1'b0;
                  state <= (nbits == '0) ? ST_STORE : ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (half_end) begin
                  phase <= !phase;
                  if (phase) begin
                     shreg <= shreg << 1;
                     left  <= left - 1'b1;
                     if (left == BIT_W'(1)) state <= ST_STORE;
                  end
               end
            end
            ST_STORE: begin
               if (half_end) begin
                  phase <= !phase;
                  if (phase) state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state != ST_IDLE);
   assign store = (state == ST_STORE);
   assign done  = (state == ST_STORE) && half_end && phase;
   assign sclk  = edge_fall ^ ((state == ST_SHIFT) && phase);
   assign sdata = (state == ST_SHIFT) && shreg[IMG_W-1];

endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
   import led_shift_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 100_000_000,
   parameter int unsigned SIM_DIV    = 1,
   parameter int unsigned NGRP       = 3,
   parameter int unsigned GRP_W      = 8,
   parameter int unsigned SHIFT_HALF = 4,
   parameter int unsigned ADDR_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [1:0]        hw_src,
   output logic              led_sdata,
   output logic              led_sclk,
   output logic              led_store
);

   localparam int unsigned IMG_W = NGRP * GRP_W;

   logic             eng_busy, eng_done, req_pend, edge_fall, periodic, tick, start;
   logic [1:0]       ovr;
   logic [3:0]       rate;
   logic [NGRP-1:0]  grp_en;
   logic [IMG_W-1:0] image;

   led_shift_regs #(
      .ADDR_W (ADDR_W),
      .NGRP   (NGRP),
      .GRP_W  (GRP_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wen   (bus_wen),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .busy      (eng_busy),
      .done      (eng_done),
      .req_pend  (req_pend),
      .edge_fall (edge_fall),
      .ovr       (ovr),
      .periodic  (periodic),
      .rate      (rate),
      .grp_en    (grp_en),
      .image     (image)
   );

   led_shift_rate #(
      .CLK_HZ  (CLK_HZ),
      .SIM_DIV (SIM_DIV)
   ) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (periodic),
      .code  (rate),
      .tick  (tick)
   );

   assign start = periodic ? tick : req_pend;

   led_shift_engine #(
      .NGRP  (NGRP),
      .GRP_W (GRP_W),
      .HALF  (SHIFT_HALF)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .image     (image),
      .grp_en    (grp_en),
      .ovr       (ovr),
      .hw_src    (hw_src),
      .edge_fall (edge_fall),
      .sclk      (led_sclk),
      .sdata     (led_sdata),
      .store     (led_store),
      .busy      (eng_busy),
      .done      (eng_done)
   );

endmodule

// File: rtl/led_shift_chk.sv
module led_shift_chk (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic sdata,
   input logic store,
   input logic busy,
   input logic edge_fall,
   input logic req,
   input logic periodic
);

   // R1: between refreshes the pins rest
   p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!store && sclk == edge_fall));

   // R4: data moves only while the shift clock is at idle level
   p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(sdata)) |-> (sclk == edge_fall));

   // R5: shift clock idle while the strobe is high
   p_store_clk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      store |-> (sclk == edge_fall));

   // R7: the request clears only as its refresh ends
   p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> $fell(busy));

   // R7 / R8: a refresh begins only on a request or in periodic mode
   p_start_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req || periodic));

endmodule

bind led_shift_ctrl led_shift_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk      (led_sclk),
   .sdata     (led_sdata),
   .store     (led_store),
   .busy      (eng_busy),
   .edge_fall (edge_fall),
   .req       (req_pend),
   .periodic  (periodic)
);

// File: tb/tb_led_shift_ctrl.sv
module tb_led_shift_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 4000;
   localparam int HALF       = 2;
   localparam int NV         = 6;

   typedef struct packed {
      logic [23:0] img;
      logic [2:0]  grp;
      logic        edge_f;
      logic [1:0]  ovr;
      logic [1:0]  hw;
      logic [23:0] exp_v;
      logic [5:0]  nb;
   } vec_t;

   // R3, R6, R11 vectors: stimulus and expected chain content
   localparam vec_t VECS [NV] = '{
      '{24'hA5C30F, 3'b111, 1'b0, 2'b00, 2'b00, 24'hA5C30F, 6'd24},
      '{24'h123456, 3'b001, 1'b1, 2'b00, 2'b00, 24'h000056, 6'd8},
      '{24'h123456, 3'b101, 1'b0, 2'b00, 2'b00, 24'h001256, 6'd16},
      '{24'hFFFFFF, 3'b111, 1'b1, 2'b11, 2'b01, 24'hFFFFFD, 6'd24},
      '{24'h000000, 3'b001, 1'b0, 2'b10, 2'b10, 24'h000002, 6'd8},
      '{24'h5A5A5A, 3'b000, 1'b0, 2'b00, 2'b00, 24'h000000, 6'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  hw_src = '0;
   logic        led_sdata, led_sclk, led_store;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   // behavioural chain model
   logic        edge_m = 1'b0;
   logic        prev_sclk = 1'b0, prev_store = 1'b0;
   logic [23:0] cap = '0, lat = '0;
   int          ncap = 0, lat_n = 0, store_cnt = 0, rise_t = 0, hi = 0, width = 0;

   led_shift_ctrl #(
      .CLK_HZ     (CLK_HZ),
      .SIM_DIV    (1),
      .NGRP       (3),
      .GRP_W      (8),
      .SHIFT_HALF (HALF),
      .ADDR_W     (5)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wen   (bus_wen),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .hw_src    (hw_src),
      .led_sdata (led_sdata),
      .led_sclk  (led_sclk),
      .led_store (led_store)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (edge_m ? (prev_sclk && !led_sclk) : (!prev_sclk && led_sclk)) begin
         cap  <= {cap[22:0], led_sdata};
         ncap <= ncap + 1;
      end
      if (led_store && !prev_store) begin
         lat       <= cap;
         lat_n     <= ncap;
         cap       <= '0;
         ncap      <= 0;
         store_cnt <= store_cnt + 1;
         rise_t    <= cyc;
         hi        <= 1;
      end else if (led_store) begin
         hi <= hi + 1;
      end
      if (!led_store && prev_store) width <= hi;
      prev_sclk  <= led_sclk;
      prev_store <= led_store;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wen   = 1'b1;
      @(negedge clk);
      bus_wen   = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_stores(input int target);
      for (int k = 0; k < 6000; k++) begin
         @(negedge clk);
         #1;
         if (store_cnt >= target && !led_store) break;
      end
   endtask

   function automatic logic [31:0] mk_cfg(input logic [1:0] upd, input logic [3:0] rate,
                                          input logic [2:0] grp);
      logic [31:0] w = '0;
      w[31:30] = upd;
      w[26:23] = rate;
      w[2:0]   = grp;
      return w;
   endfunction

   function automatic logic [31:0] mk_ctl(input logic req, input logic e, input logic [1:0] o);
      logic [31:0] w = '0;
      w[31]    = req;
      w[26]    = e;
      w[25:24] = o;
      return w;
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=finish", cyc);
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [23:0] mask;
      int t1, t2, c0;

      repeat (3) @(negedge clk);
      // R1: reset state
      check(led_sclk == 1'b0 && led_store == 1'b0 && led_sdata == 1'b0, "R1", "pins in reset",
            {29'b0, led_sclk, led_store, led_sdata}, 32'h0);
      rst_n = 1'b1;
      bus_read(5'h00, rd); check(rd == 32'h0, "R1", "control after reset", rd, 32'h0);
      bus_read(5'h04, rd); check(rd == 32'h0, "R1", "config after reset", rd, 32'h0);
      bus_read(5'h08, rd); check(rd == 32'h0, "R1", "image after reset", rd, 32'h0);

      // R2: field layout
      bus_write(5'h08, 32'hFFFF_FFFF);
      bus_read(5'h08, rd); check(rd == 32'h00FF_FFFF, "R2", "image width", rd, 32'h00FF_FFFF);
      bus_write(5'h04, 32'h3FFF_FFFF);
      bus_read(5'h04, rd); check(rd == 32'h0780_0007, "R2", "config fields", rd, 32'h0780_0007);
      bus_read(5'h0C, rd); check(rd == 32'h0, "R2", "unmapped offset", rd, 32'h0);
      bus_write(5'h04, 32'h0);

      // R3, R4, R6, R7, R11: vector table in software mode
      for (int i = 0; i < NV; i++) begin
         hw_src = VECS[i].hw;
         edge_m = VECS[i].edge_f;
         bus_write(5'h04, mk_cfg(2'b00, 4'd0, VECS[i].grp));
         bus_write(5'h08, {8'h00, VECS[i].img});
         bus_write(5'h00, mk_ctl(1'b0, VECS[i].edge_f, VECS[i].ovr));
         repeat (2) @(negedge clk);
         c0 = store_cnt;
         bus_write(5'h00, mk_ctl(1'b1, VECS[i].edge_f, VECS[i].ovr));
         wait_stores(c0 + 1);
         mask = (VECS[i].nb >= 24) ? 24'hFFFFFF : ((24'h1 << VECS[i].nb) - 24'h1);
         check(lat_n == int'(VECS[i].nb), "R3/R11", "bits shifted", lat_n, VECS[i].nb);
         check((lat & mask) == VECS[i].exp_v, "R3/R6", "chain content", lat & mask,
               VECS[i].exp_v);
         bus_read(5'h00, rd);
         check(rd[31] == 1'b0, "R7", "request cleared", rd, 32'h0);
         check(led_sclk == VECS[i].edge_f, "R4", "idle clock level", led_sclk,
               VECS[i].edge_f);
      end

      // R5: strobe width of the last refresh
      check(width == 2 * HALF, "R5", "store width", width, 2 * HALF);

      // R10 and R7: snapshot isolation, status during refresh
      edge_m = 1'b0;
      bus_write(5'h00, mk_ctl(1'b0, 1'b0, 2'b00));
      bus_write(5'h04, mk_cfg(2'b00, 4'd0, 3'b111));
      bus_write(5'h08, 32'h00C0FFEE);
      c0 = store_cnt;
      bus_write(5'h00, mk_ctl(1'b1, 1'b0, 2'b00));
      repeat (20) @(negedge clk);
      bus_read(5'h00, rd);
      check(rd[31:30] == 2'b11, "R7", "request and busy during refresh", rd[31:30], 2'b11);
      bus_write(5'h08, 32'h0);
      wait_stores(c0 + 1);
      check(lat == 24'hC0FFEE && lat_n == 24, "R10", "snapshot kept", lat, 24'hC0FFEE);

      // R8: periodic intervals
      bus_write(5'h04, mk_cfg(2'b10, 4'd0, 3'b001));
      c0 = store_cnt;
      wait_stores(c0 + 2); t1 = rise_t;
      wait_stores(c0 + 3); t2 = rise_t;
      check(t2 - t1 == CLK_HZ / 2, "R8", "2 Hz interval", t2 - t1, CLK_HZ / 2);

      bus_write(5'h04, mk_cfg(2'b10, 4'd3, 3'b001));
      c0 = store_cnt;
      wait_stores(c0 + 2); t1 = rise_t;
      wait_stores(c0 + 3); t2 = rise_t;
      check(t2 - t1 == CLK_HZ / 10, "R8", "10 Hz interval", t2 - t1, CLK_HZ / 10);

      bus_write(5'h04, mk_cfg(2'b10, 4'd9, 3'b001));
      c0 = store_cnt;
      wait_stores(c0 + 2); t1 = rise_t;
      wait_stores(c0 + 3); t2 = rise_t;
      check(t2 - t1 == CLK_HZ / 10, "R8", "out-of-range code interval", t2 - t1, CLK_HZ / 10);

      // R9: request ignored in periodic mode
      bus_write(5'h00, mk_ctl(1'b1, 1'b0, 2'b00));
      bus_read(5'h00, rd);
      check(rd[31] == 1'b0, "R9", "request in periodic mode", rd[31], 1'b0);
      bus_write(5'h04, mk_cfg(2'b00, 4'd0, 3'b001));
      repeat (200) @(negedge clk);

      summary();
      $finish;
   end

endmodule